// File: doc/BRIEF.md
# Phase-Accumulating Oscillator Channel With Carry-Pulse Output

The block is a numerically controlled oscillator for one counter channel of a microcontroller. On each system clock, while enabled, a 32-bit step value is added to a 32-bit phase register, and the sum wraps modulo 2^32. The output pin carries one of two signals. In square-wave mode it carries the top bit of the phase. In pulse mode it carries the carry out of the most recent addition. A third setting stops the accumulation and holds the pin low.

Software sets up the channel through a small word-wide register bus. It can write the mode, the step and the phase, and it can read all three back. The output frequency is step/2^32 of the clock rate for steps up to 2^31. Above that point the frequency folds back, so a step X and a step 2^32−X toggle at the same rate. A step that is not a power of two gives an uneven high/low pattern, but the average rate stays correct. The pin is driven from a register, so it follows the phase update by one clock.

Top module: `nco_counter`

## Requirements
- R1: After reset the mode, step and phase registers all read as zero and `pin_out` is low.
- R2: Mode codes 0 and 3 mean off. The phase does not advance, and at the next clock edge `pin_out` goes low.
- R3: Mode codes 1 and 2 make the phase become (phase + step) mod 2^32 at every clock edge, unless a phase write happens at that edge.
- R4: In mode 1, `pin_out` equals bit 31 of the phase value from one clock earlier. A step of 0x8000_0000 with the phase at zero gives the pin pattern 0,1,0,1.
- R5: In mode 1, a step of 0x4000_0000 with the phase at zero gives the repeating pin pattern 0,0,1,1, which is a quarter of the clock rate.
- R6: In mode 2, `pin_out` equals the carry out of the addition made one clock earlier. With a step of 0x3000_0000 there are exactly 48 high cycles in any 256 consecutive cycles.
- R7: In mode 1, a step X and the step 2^32−X give the same number of rising pin edges, within one, over the same window. For example 0x3000_0000 and 0xD000_0000 both give 48 ±1 in 256 cycles.
- R8: A step that is not a power of two keeps the correct average rate. In mode 1, 0x3000_0000 gives 48 ±1 rising edges in 256 cycles.
- R9: A phase write loads `bus_wdata` into the phase at that edge and clears the carry. It overrides that cycle's accumulation.
- R10: Register map:
  - Address 0 holds the mode in bits 1:0 and reads as zero above them.
  - Address 1 holds the step.
  - Address 2 holds the phase.
  - Address 3 reads as zero and ignores writes.
  - `bus_rdata` shows the addressed register combinationally.
  - A write takes effect at the clock edge on which `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_out | output | 1 | Registered oscillator output |

## Verification
Directed steps separate the output behaviours:
- 0x8000_0000 tests the fastest toggle.
- 0x4000_0000 tests the quarter-rate square wave.
- 0x3000_0000 and its mirror 0xD000_0000 show that the fold-back above 2^31 gives the same edge count as the low step.
- Pulse mode with the same step shows that the carry, not the top bit, is routed to the pin.

Random bus traffic mixes mode, step and phase writes with idle cycles. It compares the pin and every readback each cycle against a bench model. This exposes errors in write priority, in the one-clock output lag, and in the off mode.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SQR  = 2'd1,
    MODE_PULS = 2'd2,
    MODE_IDLE = 2'd3
  } nco_mode_e;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STEP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PHASE = 2'd2;

  function automatic logic mode_runs(input logic [1:0] m);
    return (m == MODE_SQR) || (m == MODE_PULS);
  endfunction
endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mode,
  input  logic         wr_step,
  input  logic [W-1:0] wdata,
  output logic [1:0]   mode_q,
  output logic [W-1:0] step_q
);
  logic [1:0]   mode_d;
  logic [W-1:0] step_d;

  always_comb begin
    mode_d = mode_q;
    step_d = step_q;
    if (wr_mode) mode_d = wdata[1:0];
    if (wr_step) step_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      step_q <= '0;
    end else begin
      mode_q <= mode_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] step,
  output logic [W-1:0] phase_q,
  output logic         carry_q
);
  logic [W:0]   sum;
  logic [W-1:0] phase_d;
  logic         carry_d;
  logic         en;

  assign sum = {1'b0, phase_q} + {1'b0, step};
  assign en  = load | run;

  always_comb begin
    phase_d = phase_q;
    carry_d = 1'b0;
    if (load) begin
      phase_d = load_val;
    end else if (run) begin
      phase_d = sum[W-1:0];
      carry_d = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (en) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end
endmodule

// File: rtl/nco_pin_drv.sv
module nco_pin_drv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       msb,
  input  logic       carry,
  output logic       pin_q
);
  import nco_pkg::*;
  logic pin_d;

  always_comb begin
    unique case (mode)
      MODE_SQR:  pin_d = msb;
      MODE_PULS: pin_d = carry;
      default:   pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end
endmodule

// File: rtl/nco_counter.sv
module nco_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pin_out
);
  import nco_pkg::*;

  logic [1:0]   mode_q;
  logic [W-1:0] step_q;
  logic [W-1:0] phase_q;
  logic         carry_q;
  logic         wr_mode, wr_step, wr_phase;

  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign wr_step  = bus_wr && (bus_addr == A_STEP);
  assign wr_phase = bus_wr && (bus_addr == A_PHASE);

  nco_cfg_regs #(.W(W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mode(wr_mode),
    .wr_step(wr_step),
    .wdata  (bus_wdata),
    .mode_q (mode_q),
    .step_q (step_q)
  );

  nco_phase_acc #(.W(W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode_runs(mode_q)),
    .load    (wr_phase),
    .load_val(bus_wdata),
    .step    (step_q),
    .phase_q (phase_q),
    .carry_q (carry_q)
  );

  nco_pin_drv u_pin (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (mode_q),
    .msb  (phase_q[W-1]),
    .carry(carry_q),
    .pin_q(pin_out)
  );

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = {{(W-2){1'b0}}, mode_q};
      A_STEP:  bus_rdata = step_q;
      A_PHASE: bus_rdata = phase_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nco_counter_chk.sv
module nco_counter_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [1:0]   mode_q,
  input logic [W-1:0] step_q,
  input logic [W-1:0] phase_q,
  input logic         carry_q,
  input logic         pin_out
);
  logic ph_wr;
  logic runs;
  assign ph_wr = bus_wr && (bus_addr == 2'd2);
  assign runs  = (mode_q == 2'd1) || (mode_q == 2'd2);

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!runs && !ph_wr) |=> $stable(phase_q));

  // R2
  off_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runs |=> !pin_out);

  // R3
  accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runs && !ph_wr) |=> (phase_q == $past(phase_q + step_q)));

  // R4
  sqr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |=> (pin_out == $past(phase_q[W-1])));

  // R6
  puls_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |=> (pin_out == $past(carry_q)));

  // R9
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_wr |=> ((phase_q == $past(bus_wdata)) && !carry_q));
endmodule

bind nco_counter nco_counter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .mode_q   (mode_q),
  .step_q   (step_q),
  .phase_q  (phase_q),
  .carry_q  (carry_q),
  .pin_out  (pin_out)
);

// File: tb/tb_nco_counter.sv
`timescale 1ns/1ps
module tb_nco_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nco_counter dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out)
  );

  // bench model built from the requirements
  logic [1:0]  m_mode;
  logic [31:0] m_step, m_phase;
  logic        m_carry, m_pin;

  function automatic bit runs(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {30'd0, m_mode};
      2'd1:    return m_step;
      2'd2:    return m_phase;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 2'd0; m_step <= '0; m_phase <= '0; m_carry <= 1'b0; m_pin <= 1'b0;
    end else begin
      m_pin <= (m_mode == 2'd1) ? m_phase[31] : (m_mode == 2'd2) ? m_carry : 1'b0;
      if (bus_wr && bus_addr == 2'd0) m_mode <= bus_wdata[1:0];
      if (bus_wr && bus_addr == 2'd1) m_step <= bus_wdata;
      if (bus_wr && bus_addr == 2'd2) begin
        m_phase <= bus_wdata; m_carry <= 1'b0;
      end else if (runs(m_mode)) begin
        {m_carry, m_phase} <= {1'b0, m_phase} + {1'b0, m_step};
      end else begin
        m_carry <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // advance one cycle and compare the ports with the model
  task automatic tick(input string tag);
    @(negedge clk);
    check({tag, " pin"}, {31'd0, pin_out}, {31'd0, m_pin});
    check({tag, " rdata"}, bus_rdata, exp_rd(bus_addr));
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick("R10 write");
    bus_wr = 1'b0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [31:0] st);
    wr(2'd0, 32'd0);
    wr(2'd1, st);
    wr(2'd2, 32'd0);
    wr(2'd0, {30'd0, md});
  endtask

  task automatic count_rise(input int cyc, output int rises, output int highs);
    logic prev;
    rises = 0; highs = 0;
    prev = pin_out;
    for (int i = 0; i < cyc; i++) begin
      tick("R3 run");
      if (pin_out && !prev) rises++;
      if (pin_out) highs++;
      prev = pin_out;
    end
  endtask

  initial begin
    int r1, h1, r2, h2;
    logic [7:0] pat;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr = a[1:0];
      #1 check("R1 reset readback", bus_rdata, 32'd0);
    end
    check("R1 reset pin", {31'd0, pin_out}, 32'd0);
    rst_n = 1'b1;
    tick("R1 after reset");

    // R2 off mode: step loaded but nothing advances
    wr(2'd1, 32'h1234_5678);
    bus_addr = 2'd2;
    repeat (5) tick("R2 off");
    check("R2 off phase held", bus_rdata, 32'd0);
    check("R2 off pin low", {31'd0, pin_out}, 32'd0);

    // R4 half rate
    setup(2'd1, 32'h8000_0000);
    bus_addr = 2'd2;
    repeat (2) tick("R4 settle");
    for (int i = 0; i < 8; i++) begin
      tick("R4 half");
      pat[i] = pin_out;
    end
    for (int i = 1; i < 8; i++)
      check("R4 alternates", {31'd0, pat[i]}, {31'd0, ~pat[i-1]});

    // R5 quarter rate
    setup(2'd1, 32'h4000_0000);
    repeat (2) tick("R5 settle");
    for (int i = 0; i < 8; i++) begin
      tick("R5 quarter");
      pat[i] = pin_out;
    end
    for (int i = 0; i < 4; i++)
      check("R5 period four", {31'd0, pat[i+4]}, {31'd0, pat[i]});
    check("R5 two apart differ", {31'd0, pat[2]}, {31'd0, ~pat[0]});
    check("R5 pairs equal", {31'd0, pat[1]^pat[0]^pat[3]^pat[2]}, 32'd0);

    // R8 / R7 non power of two and mirror
    setup(2'd1, 32'h3000_0000);
    repeat (4) tick("R8 settle");
    count_rise(256, r1, h1);
    check_rng("R8 average rate", r1, 47, 48);
    setup(2'd1, 32'hD000_0000);
    repeat (4) tick("R7 settle");
    count_rise(256, r2, h2);
    check_rng("R7 mirror rate", r2, 47, 48);
    check_rng("R7 mirror equal", r2 - r1, -1, 1);

    // R6 carry pulses
    setup(2'd2, 32'h3000_0000);
    repeat (4) tick("R6 settle");
    count_rise(256, r1, h1);
    check_rng("R6 carry pulses", h1, 48, 48);

    // R9 phase write during accumulation
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'hFFFF_FFF0;
    tick("R9 load");
    bus_wr = 1'b0;
    check("R9 loaded value", bus_rdata, 32'hFFFF_FFF0);

    // R10 address 3 ignored
    wr(2'd3, 32'hFFFF_FFFF);
    bus_addr = 2'd3;
    #1 check("R10 addr3 reads zero", bus_rdata, 32'd0);
    bus_addr = 2'd0;
    #1 check("R10 mode unchanged", bus_rdata, 32'd2);

    // random traffic against the model (R2 R3 R4 R6 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      bus_addr = r[1:0];
      bus_wr = (r[4:2] == 3'd0);
      case (r[7:5])
        3'd0:    bus_wdata = 32'h8000_0000;
        3'd1:    bus_wdata = 32'hFFFF_FFFF;
        3'd2:    bus_wdata = 32'd0;
        default: bus_wdata = $urandom;
      endcase
      tick("R3 random");
    end
    bus_wr = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule